// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block accepts interrupt requests for any of 256 vectors on behalf of one processor and decides when the processor should be interrupted and which vector it should service. Three 256-bit state vectors are kept: the pending set, the in-service set and a per-vector trigger-kind record (level or edge). Vector numbers double as priorities: a larger number always wins, and vectors are grouped into sixteen classes of sixteen vectors each for priority comparisons.

Software controls the block through a task-priority value and a 9-bit control word whose top bit enables the controller and whose low byte is the vector handed out when an acknowledge is refused. The processor sees one registered pending line, acknowledges to receive a vector, and writes an end-of-interrupt to retire the highest in-service vector. The effective processor priority, the greater of the task priority and the class of the highest in-service vector, is exposed for reading. A peek port shows the three per-vector bits of any one vector.

Top module: `vic_ctrl`

## Requirements
- R1: After reset the pending, in-service and trigger-kind sets are empty, the task priority is 0, the control word is 0x0FF (controller disabled), the pending line is low and the processor priority reads 0.
- R2: A request sets the pending bit of its vector; with trigger kind 1 (level) it sets that vector's trigger-kind bit, with kind 0 (edge) it clears it.
- R3: A withdraw for a vector whose trigger-kind bit is 1 clears its pending bit; for an edge vector it changes nothing, and the in-service bit is never touched by it.
- R4: The highest pending vector is the largest vector number with its pending bit set.
- R5: The processor priority equals the task priority when the task priority's class (bits 7:4) is at least the class of the highest in-service vector (0 when none is in service); otherwise it is that class followed by four zero bits.
- R6: The pending line is high only when the control word's bit 8 is 1, some vector is pending, and either the processor priority is 0 or the highest pending vector's class is strictly above the processor priority's class.
- R7: The pending line is registered: it reflects the state as it stood one clock after that state changed.
- R8: An accepted acknowledge clears the highest pending bit, sets the same vector's in-service bit and returns that vector, with the response valid for one cycle the clock after the request.
- R9: If the task priority is nonzero and the highest pending vector is not above it, an acknowledge returns the control word's low byte and changes no pending or in-service bit.
- R10: With the controller disabled, or nothing pending, an acknowledge returns the no-interrupt flag with vector 0 and changes no state.
- R11: An end-of-interrupt clears the highest set in-service bit; with the in-service set empty it does nothing.
- R12: Writes of the control word and task priority take effect at the next clock and the control word reads back as all 9 bits written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_req | input | 1 | Raise a request for set_vec this cycle |
| set_vec | input | 8 | Vector of the request |
| set_trig | input | 1 | Trigger kind: 1 level, 0 edge |
| clr_req | input | 1 | Withdraw a level request for clr_vec |
| clr_vec | input | 8 | Vector being withdrawn |
| tpr_wr | input | 1 | Write task priority |
| tpr_wdata | input | 8 | New task priority |
| ctl_wr | input | 1 | Write control word |
| ctl_wdata | input | 9 | New control word (bit 8 enable, low byte refusal vector) |
| eoi_wr | input | 1 | End-of-interrupt |
| ack_req | input | 1 | Processor acknowledge |
| ack_valid | output | 1 | Acknowledge response valid |
| ack_none | output | 1 | No interrupt available |
| ack_vec | output | 8 | Vector returned by the acknowledge |
| irq_pending | output | 1 | Registered interrupt line to the processor |
| ppr_out | output | 8 | Current processor priority |
| ctl_out | output | 9 | Current control word |
| tpr_out | output | 8 | Current task priority |
| peek_vec | input | 8 | Vector to inspect |
| peek_pend | output | 1 | Pending bit of peek_vec |
| peek_serv | output | 1 | In-service bit of peek_vec |
| peek_level | output | 1 | Trigger-kind bit of peek_vec |

## Verification
Every operation lands in the state registers at the clock that samples it, so the peek outputs, the processor priority and the acknowledge response are due one clock after the stimulus, while the pending line is due one clock later still. The bench drives on falling edges and applies each operation for exactly one cycle, then checks the pending line at the first falling edge against the value its model held before the operation and at the second against the model after it. All 256 vectors are swept through request, acknowledge and retire, and all sixteen task-priority classes are crossed with vectors below, inside and above each class.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int VEC_W   = 8;
    localparam int LOW_W   = 4;
    localparam int CLS_W   = VEC_W - LOW_W;
    localparam int NUM_VEC = 1 << VEC_W;
    localparam int CTL_W   = VEC_W + 1;

    typedef logic [VEC_W-1:0]   vec_t;
    typedef logic [CLS_W-1:0]   cls_t;
    typedef logic [NUM_VEC-1:0] vset_t;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    typedef struct packed {
        logic valid;
        logic none;
        vec_t vec;
    } ack_rsp_t;

    function automatic cls_t cls_of(input vec_t v);
        return v[VEC_W-1:LOW_W];
    endfunction
endpackage

// File: rtl/vic_msb_find.sv
module vic_msb_find #(
    parameter int W  = 256,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  bits,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |bits;
        idx   = '0;
        for (int i = 0; i < W; i++) begin
            if (bits[i]) idx = i[IW-1:0];
        end
    end
endmodule

// File: rtl/vic_prio.sv
module vic_prio
    import vic_pkg::*;
(
    input  logic enable,
    input  vec_t tpr,
    input  logic serv_found,
    input  vec_t serv_top,
    input  logic pend_found,
    input  vec_t pend_top,
    output vec_t ppr,
    output logic irq_want,
    output logic refuse
);
    cls_t serv_cls;

    always_comb begin
        serv_cls = serv_found ? cls_of(serv_top) : '0;
        if (cls_of(tpr) >= serv_cls) ppr = tpr;
        else                         ppr = {serv_cls, {LOW_W{1'b0}}};
        irq_want = enable && pend_found &&
                   ((ppr == '0) || (cls_of(pend_top) > cls_of(ppr)));
        refuse   = (tpr != '0) && (pend_top <= tpr);
    end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
    import vic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set_req,
    input  logic [VEC_W-1:0] set_vec,
    input  logic             set_trig,
    input  logic             clr_req,
    input  logic [VEC_W-1:0] clr_vec,
    input  logic             tpr_wr,
    input  logic [VEC_W-1:0] tpr_wdata,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             eoi_wr,
    input  logic             ack_req,
    output logic             ack_valid,
    output logic             ack_none,
    output logic [VEC_W-1:0] ack_vec,
    output logic             irq_pending,
    output logic [VEC_W-1:0] ppr_out,
    output logic [CTL_W-1:0] ctl_out,
    output logic [VEC_W-1:0] tpr_out,
    input  logic [VEC_W-1:0] peek_vec,
    output logic             peek_pend,
    output logic             peek_serv,
    output logic             peek_level
);
    localparam logic [CTL_W-1:0] CTL_RST = {1'b0, {VEC_W{1'b1}}};

    vset_t    pend_q, serv_q, lvl_q;
    vset_t    pend_n, serv_n, lvl_n;
    vec_t     tpr_q;
    logic [CTL_W-1:0] ctl_q;
    logic     irq_q;
    ack_rsp_t rsp_q, rsp_n;

    logic enable, pend_found, serv_found, irq_want, refuse, take;
    vec_t pend_top, serv_top, ppr;

    assign enable = ctl_q[VEC_W];

    vic_msb_find #(.W(NUM_VEC)) u_pend_find (
        .bits(pend_q), .found(pend_found), .idx(pend_top)
    );
    vic_msb_find #(.W(NUM_VEC)) u_serv_find (
        .bits(serv_q), .found(serv_found), .idx(serv_top)
    );

    vic_prio u_prio (
        .enable(enable), .tpr(tpr_q),
        .serv_found(serv_found), .serv_top(serv_top),
        .pend_found(pend_found), .pend_top(pend_top),
        .ppr(ppr), .irq_want(irq_want), .refuse(refuse)
    );

    assign take = ack_req && enable && pend_found && !refuse;

    // Next state: retire, accept, withdraw, then raise (a raise wins last)
    always_comb begin
        pend_n = pend_q;
        serv_n = serv_q;
        lvl_n  = lvl_q;
        if (eoi_wr && serv_found) serv_n[serv_top] = 1'b0;
        if (take) begin
            pend_n[pend_top] = 1'b0;
            serv_n[pend_top] = 1'b1;
        end
        if (clr_req && lvl_q[clr_vec]) pend_n[clr_vec] = 1'b0;
        if (set_req) begin
            pend_n[set_vec] = 1'b1;
            lvl_n[set_vec]  = (trig_e'(set_trig) == TRIG_LEVEL);
        end
    end

    always_comb begin
        rsp_n.valid = ack_req;
        rsp_n.none  = 1'b0;
        rsp_n.vec   = '0;
        if (!enable || !pend_found) rsp_n.none = 1'b1;
        else if (refuse)            rsp_n.vec  = ctl_q[VEC_W-1:0];
        else                        rsp_n.vec  = pend_top;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            serv_q <= '0;
            lvl_q  <= '0;
            tpr_q  <= '0;
            ctl_q  <= CTL_RST;
            irq_q  <= 1'b0;
            rsp_q  <= '0;
        end else begin
            pend_q <= pend_n;
            serv_q <= serv_n;
            lvl_q  <= lvl_n;
            irq_q  <= irq_want;
            rsp_q  <= rsp_n;
            if (tpr_wr) tpr_q <= tpr_wdata;
            if (ctl_wr) ctl_q <= ctl_wdata;
        end
    end

    assign ack_valid   = rsp_q.valid;
    assign ack_none    = rsp_q.none;
    assign ack_vec     = rsp_q.vec;
    assign irq_pending = irq_q;
    assign ppr_out     = ppr;
    assign ctl_out     = ctl_q;
    assign tpr_out     = tpr_q;
    assign peek_pend   = pend_q[peek_vec];
    assign peek_serv   = serv_q[peek_vec];
    assign peek_level  = lvl_q[peek_vec];

    // R8: a response only follows an acknowledge one clock earlier
    p_rsp_after_ack_r8: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> $past(ack_req));

    // R5: the processor priority never drops below the task priority
    p_ppr_floor_r5: assert property (@(posedge clk) disable iff (rst)
        ppr_out >= tpr_q);

    // R6: the line stays low when the controller was disabled
    p_irq_needs_enable_r6: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !irq_pending);

    // R11: a retire with something in service removes exactly one bit
    p_eoi_one_bit_r11: assert property (@(posedge clk) disable iff (rst)
        (eoi_wr && serv_found && !ack_req) |=>
        ($countones(serv_q) == $past($countones(serv_q)) - 1));

    // R9: a refused acknowledge leaves both sets untouched
    p_refuse_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (ack_req && enable && pend_found && refuse &&
         !set_req && !clr_req && !eoi_wr) |=>
        ($stable(pend_q) && $stable(serv_q)));

    // R10: a disabled controller answers with the no-interrupt flag
    p_disabled_none_r10: assert property (@(posedge clk) disable iff (rst)
        (ack_req && !enable) |=> (ack_valid && ack_none));
endmodule

// File: tb/vic_ctrl_tb.sv
`timescale 1ns/1ps
module vic_ctrl_tb_top;
    localparam int CLK_NS = 20;
    localparam int K_NOP = 0, K_SET = 1, K_CLR = 2, K_TPR = 3,
                   K_CTL = 4, K_EOI = 5, K_ACK = 6;

    logic clk = 1'b0, rst = 1'b1;
    logic set_req = 0, set_trig = 0, clr_req = 0, tpr_wr = 0, ctl_wr = 0;
    logic eoi_wr = 0, ack_req = 0;
    logic [7:0] set_vec = 0, clr_vec = 0, tpr_wdata = 0, peek_vec = 0;
    logic [8:0] ctl_wdata = 0;
    logic ack_valid, ack_none, irq_pending, peek_pend, peek_serv, peek_level;
    logic [7:0] ack_vec, ppr_out, tpr_out;
    logic [8:0] ctl_out;

    int total = 0, fails = 0;
    logic [255:0] m_pend = '0, m_serv = '0, m_lvl = '0;
    int m_tpr = 0, m_ctl = 'h0FF;

    always #(CLK_NS/2) clk = ~clk;

    vic_ctrl dut_i (.*);

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int top_of(input logic [255:0] b);
        int r = -1;
        for (int i = 0; i < 256; i++) if (b[i]) r = i;
        return r;
    endfunction

    function automatic int m_ppr();
        int sc = (top_of(m_serv) < 0) ? 0 : (top_of(m_serv) >> 4);
        return ((m_tpr >> 4) >= sc) ? m_tpr : (sc << 4);
    endfunction

    function automatic int m_irq();
        int h = top_of(m_pend);
        int p = m_ppr();
        if (m_ctl[8] == 0 || h < 0) return 0;
        return (p == 0 || (h >> 4) > (p >> 4)) ? 1 : 0;
    endfunction

    // One operation for one cycle, then two cycles of checks
    task automatic op(input int kind, input int v, input int d, input string tag);
        int pre_irq = m_irq();
        int h = top_of(m_pend);
        int ev = 0, en = 0, pv = v;
        if (kind == K_ACK) begin
            if (m_ctl[8] == 0 || h < 0) en = 1;
            else if (m_tpr != 0 && h <= m_tpr) ev = m_ctl & 'hFF;
            else begin ev = h; pv = h; end
        end
        peek_vec = pv[7:0];
        case (kind)
            K_SET: begin set_req = 1; set_vec = v[7:0]; set_trig = d[0]; end
            K_CLR: begin clr_req = 1; clr_vec = v[7:0]; end
            K_TPR: begin tpr_wr = 1; tpr_wdata = d[7:0]; end
            K_CTL: begin ctl_wr = 1; ctl_wdata = d[8:0]; end
            K_EOI: eoi_wr = 1;
            K_ACK: ack_req = 1;
            default: ;
        endcase
        @(negedge clk);
        {set_req, clr_req, tpr_wr, ctl_wr, eoi_wr, ack_req} = '0;
        case (kind)
            K_SET: begin m_pend[v] = 1; m_lvl[v] = d[0]; end
            K_CLR: if (m_lvl[v]) m_pend[v] = 0;
            K_TPR: m_tpr = d & 'hFF;
            K_CTL: m_ctl = d & 'h1FF;
            K_EOI: if (top_of(m_serv) >= 0) m_serv[top_of(m_serv)] = 0;
            K_ACK: if (en == 0 && ev == h) begin m_pend[h] = 0; m_serv[h] = 1; end
            default: ;
        endcase
        check({tag, " R7 line lags"}, irq_pending, pre_irq);
        check({tag, " R5 ppr"}, ppr_out, m_ppr());
        check({tag, " R2 pend bit"}, peek_pend, m_pend[pv]);
        check({tag, " R8 serv bit"}, peek_serv, m_serv[pv]);
        check({tag, " R2 level bit"}, peek_level, m_lvl[pv]);
        check({tag, " R12 ctl"}, ctl_out, m_ctl);
        check({tag, " R12 tpr"}, tpr_out, m_tpr);
        check({tag, " R8 valid"}, ack_valid, kind == K_ACK);
        if (kind == K_ACK) begin
            check({tag, " R10 none"}, ack_none, en);
            check({tag, " R9 vec"}, ack_vec, ev);
        end
        @(negedge clk);
        check({tag, " R6 line"}, irq_pending, m_irq());
    endtask

    initial begin
        #(CLK_NS * 200000);
        total++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 irq", irq_pending, 0);
        check("R1 ppr", ppr_out, 0);
        check("R1 ctl", ctl_out, 'h0FF);
        check("R1 tpr", tpr_out, 0);
        check("R1 pend", peek_pend, 0);
        // R10 disabled: request recorded, no line, acknowledge refused
        op(K_SET, 'h40, 0, "R10 dis set");
        op(K_ACK, 'h40, 0, "R10 dis ack");
        op(K_CTL, 0, 'h1E7, "R12 enable");
        op(K_ACK, 'h40, 0, "R8 first");
        op(K_EOI, 'h40, 0, "R11 first");
        op(K_EOI, 'h40, 0, "R11 empty");
        // full sweep of all vectors
        for (int v = 0; v < 256; v++) begin
            op(K_SET, v, v & 1, "R2 sweep");
            op(K_ACK, v, 0, "R4 sweep");
            op(K_EOI, v, 0, "R11 sweep");
        end
        // ordering and nesting
        op(K_SET, 'h23, 0, "R4 mix");
        op(K_SET, 'h91, 1, "R4 mix");
        op(K_SET, 'h5F, 0, "R4 mix");
        op(K_ACK, 'h91, 0, "R4 top");
        op(K_ACK, 'h5F, 0, "R5 nested");
        op(K_EOI, 'h91, 0, "R11 top first");
        op(K_EOI, 'h5F, 0, "R11 next");
        op(K_ACK, 'h23, 0, "R8 last");
        op(K_EOI, 'h23, 0, "R11 last");
        // task priority classes against vectors around them
        for (int t = 0; t < 16; t++) begin
            op(K_TPR, 0, (t << 4) | 5, "R9 tpr");
            for (int k = 0; k < 4; k++) begin
                int v = (k == 0) ? 'h05 : (k == 1) ? ((t << 4) | 3) :
                        (k == 2) ? ((t << 4) | 9) : 'hF0;
                op(K_SET, v, 0, "R6 class");
                op(K_ACK, v, 0, "R9 class");
                if (m_pend[v]) op(K_CLR, v, 0, "R3 edge stays");
                if (m_pend[v]) begin
                    op(K_TPR, 0, 0, "R9 drop");
                    op(K_ACK, v, 0, "R8 drain");
                    op(K_TPR, 0, (t << 4) | 5, "R9 restore");
                end
                op(K_EOI, v, 0, "R11 class");
            end
        end
        op(K_TPR, 0, 0, "R12 tpr clear");
        // level withdraw
        op(K_SET, 'h66, 1, "R3 level");
        op(K_CLR, 'h66, 0, "R3 withdraw");
        op(K_SET, 'h68, 1, "R3 level2");
        op(K_ACK, 'h68, 0, "R3 take");
        op(K_CLR, 'h68, 0, "R3 after take");
        op(K_EOI, 'h68, 0, "R11 level");
        // disabling with a request pending
        op(K_SET, 'hA0, 0, "R6 pend");
        op(K_CTL, 0, 'h0E7, "R6 disable");
        op(K_ACK, 'hA0, 0, "R10 disabled");
        op(K_NOP, 'hA0, 0, "R10 unchanged");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule